// File: doc/BRIEF.md
# Oversampling UART Receiver with Multidrop Wake-up

This block recovers asynchronous NRZ characters from a serial line. The line is observed only on cycles where a tick input is high; that tick runs at sixteen times the bit rate and comes from a baud divider outside the block. Each bit is resolved from three samples near its centre by majority vote. A finished character lands in a holding register, together with a full flag and a set of sticky error flags. Software clears the full flag and the error flags by pulsing a read strobe.

Characters carry 8 or 9 data bits, least significant bit first. Parity checking can be enabled on the final data bit. An idle detector reports a quiet line. It measures from the end of the stop bit, or, in a short mode, from the start bit.

For multidrop buses the receiver can be put to sleep. While asleep it discards frames. It wakes either when the line goes idle or when a frame arrives whose top data bit is set. In the second case that address frame is delivered.

Top module: `uart_wake_rx`

## Requirements
- R1: A start is detected on a tick where `rxd` is 0 after it was 1 on the previous tick; that tick is slot 1 of the bit, and slots run 1 to 16. A bit's value is the majority of its samples at slots 8, 9 and 10. A start bit that votes 1 is discarded with no flag and no data.
- R2: When the three samples of any bit in a delivered frame differ, `err_noise` sets. The data still takes the majority value.
- R3: With `nine_bit`=0 a frame has 8 data bits, delivered on `rx_data` with `rx_bit8`=0. With `nine_bit`=1 it has 9 data bits, and the ninth appears on `rx_bit8`. Data bits arrive least significant first.
- R4: With `par_en`=1 the last data bit is parity. The XOR of all data bits must equal `par_odd` (0 even, 1 odd), otherwise `err_parity` sets.
- R5: A stop bit that votes 0 sets `err_frame`. The frame is still delivered.
- R6: `rx_full` sets when a frame is loaded into the holding register. A one-cycle `stat_rd` pulse clears `rx_full` and every error and idle flag.
- R7: A frame that completes while `rx_full` is 1 leaves `rx_data`/`rx_bit8` unchanged and sets `err_overrun`.
- R8: With `idle_long`=1, `idle_det` sets once the line has been 1 for (data bits + 2) × 16 consecutive ticks. Counting starts with stop-bit slot 11, and a 0 restarts the count.
- R9: With `idle_long`=0, idle counting starts right after the start-detection tick, so high data and stop bits count toward the idle time.
- R10: A `rwu_set` pulse sets `rwu_o`. With `wake_addr`=0, frames are discarded while `rwu_o` is 1, and an idle detection clears `rwu_o`.
- R11: With `wake_addr`=1 and `rwu_o`=1, frames whose last data bit is 0 are discarded and idle does not wake the receiver. A frame whose last data bit is 1 clears `rwu_o` and is delivered.
- R12: `rx_active` is 1 from the cycle after start detection until the frame ends or is discarded.
- R13: With `rx_en`=0 the receiver ignores the line and delivers no frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tick16 | input | 1 | Oversample tick, 16 per bit |
| rxd | input | 1 | Serial line, already synchronised |
| rx_en | input | 1 | Receiver enable |
| nine_bit | input | 1 | 1 selects 9 data bits |
| par_en | input | 1 | Parity check enable |
| par_odd | input | 1 | 1 odd parity, 0 even |
| idle_long | input | 1 | 1 idle counted after stop, 0 after start |
| wake_addr | input | 1 | 1 address-mark wake, 0 idle wake |
| rwu_set | input | 1 | Pulse that puts the receiver to sleep |
| stat_rd | input | 1 | Pulse that clears the flags |
| rx_data | output | 8 | Held data bits 7..0 |
| rx_bit8 | output | 1 | Held ninth data bit |
| rx_full | output | 1 | Holding register full |
| err_overrun | output | 1 | Overrun flag |
| err_noise | output | 1 | Noise flag |
| err_frame | output | 1 | Framing flag |
| err_parity | output | 1 | Parity flag |
| idle_det | output | 1 | Idle line flag |
| rx_active | output | 1 | Frame in progress |
| rwu_o | output | 1 | Receiver asleep |

## Verification
Some faults leave the bit slot counter or the data-bit counter in the wrong state. They show up within one frame, as shifted data, a spurious framing flag, or `rx_active` staying high past the stop bit. A fault in the idle counter's arming appears only after a full character time of quiet line, as `idle_det` or a wake-up arriving early, late or never. The bench therefore probes a few ticks on either side of the exact threshold. A fault in the sleep or overrun gating is visible on the next frame, through `rx_full`, `rwu_o` and the held data.

// File: rtl/uwr_pkg.sv
package uwr_pkg;
    typedef enum logic [1:0] {FR_IDLE, FR_START, FR_DATA, FR_STOP} fr_state_e;

    function automatic logic vote3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction
endpackage

// File: rtl/uwr_frame.sv
module uwr_frame
    import uwr_pkg::*;
#(
    parameter int OSR  = 16,
    parameter int DMAX = 9
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic            tick,
    input  logic            rxd,
    input  logic            nine,
    output logic            start_o,
    output logic            done_o,
    output logic [DMAX-1:0] data_o,
    output logic            noise_o,
    output logic            ferr_o,
    output logic            active_o
);
    localparam int SW = $clog2(OSR + 1);
    localparam int BW = $clog2(DMAX + 1);
    localparam logic [SW-1:0] SLOT_A    = SW'(OSR / 2);
    localparam logic [SW-1:0] SLOT_B    = SW'(OSR / 2 + 1);
    localparam logic [SW-1:0] SLOT_C    = SW'(OSR / 2 + 2);
    localparam logic [SW-1:0] SLOT_LAST = SW'(OSR);

    typedef struct packed {
        fr_state_e       st;
        logic [SW-1:0]   slot;
        logic [BW-1:0]   bitn;
        logic [1:0]      smp;
        logic [DMAX-1:0] sh;
        logic            nz;
        logic            prev;
        logic            done;
        logic [DMAX-1:0] dout;
        logic            nout;
        logic            fout;
    } fr_regs_t;

    fr_regs_t q_q, r_d;
    logic [BW-1:0] last_bit;
    logic [SW-1:0] slot_n;
    logic          v_maj, v_dis;

    assign last_bit = nine ? BW'(DMAX - 1) : BW'(DMAX - 2);

    always_comb begin
        r_d      = q_q;
        r_d.done = 1'b0;
        start_o  = 1'b0;
        slot_n   = (q_q.slot == SLOT_LAST) ? SW'(1) : q_q.slot + SW'(1);
        v_maj    = vote3(q_q.smp[0], q_q.smp[1], rxd);
        v_dis    = !((q_q.smp[0] == q_q.smp[1]) && (q_q.smp[1] == rxd));
        if (!en) begin
            r_d.st   = FR_IDLE;
            r_d.prev = 1'b0;
        end else if (tick) begin
            r_d.prev = rxd;
            if (q_q.st == FR_IDLE) begin
                if (!rxd && q_q.prev) begin
                    start_o  = 1'b1;
                    r_d.st   = FR_START;
                    r_d.slot = SW'(1);
                    r_d.nz   = 1'b0;
                    r_d.bitn = '0;
                end
            end else begin
                r_d.slot = slot_n;
                if (slot_n == SLOT_A) r_d.smp[0] = rxd;
                if (slot_n == SLOT_B) r_d.smp[1] = rxd;
                if (slot_n == SLOT_C) begin
                    r_d.nz = q_q.nz | v_dis;
                    case (q_q.st)
                        FR_START: r_d.st = v_maj ? FR_IDLE : FR_DATA;
                        FR_DATA: begin
                            r_d.sh   = {v_maj, q_q.sh[DMAX-1:1]};
                            r_d.bitn = q_q.bitn + BW'(1);
                            if (q_q.bitn == last_bit) r_d.st = FR_STOP;
                        end
                        FR_STOP: begin
                            r_d.st   = FR_IDLE;
                            r_d.done = 1'b1;
                            r_d.dout = nine ? q_q.sh : {1'b0, q_q.sh[DMAX-1:1]};
                            r_d.nout = q_q.nz | v_dis;
                            r_d.fout = !v_maj;
                        end
                        default: r_d.st = FR_IDLE;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '{st: FR_IDLE, default: '0};
        else        q_q <= r_d;
    end

    assign done_o   = q_q.done;
    assign data_o   = q_q.dout;
    assign noise_o  = q_q.nout;
    assign ferr_o   = q_q.fout;
    assign active_o = (q_q.st != FR_IDLE);

    // R12
    active_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> active_o);

    // R3
    done_from_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(q_q.st == FR_STOP));

    // R1
    no_start_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> !active_o);
endmodule

// File: rtl/uwr_idle.sv
module uwr_idle #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          tick,
    input  logic          rxd,
    input  logic          arm,
    input  logic [CW-1:0] target,
    output logic          hit_o
);
    typedef struct packed {
        logic          armed;
        logic [CW-1:0] cnt;
        logic          hit;
    } id_regs_t;

    id_regs_t q_q, r_d;

    always_comb begin
        r_d     = q_q;
        r_d.hit = 1'b0;
        if (!en) begin
            r_d.armed = 1'b0;
            r_d.cnt   = '0;
        end else if (arm) begin
            r_d.armed = 1'b1;
            r_d.cnt   = '0;
        end else if (tick && q_q.armed) begin
            if (!rxd) begin
                r_d.cnt = '0;
            end else if (q_q.cnt + CW'(1) == target) begin
                r_d.hit   = 1'b1;
                r_d.armed = 1'b0;
                r_d.cnt   = '0;
            end else begin
                r_d.cnt = q_q.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= r_d;
    end

    assign hit_o = q_q.hit;

    // R8
    idle_hit_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> $past(q_q.armed));
endmodule

// File: rtl/uart_wake_rx.sv
module uart_wake_rx #(
    parameter int OSR  = 16,
    parameter int DMAX = 9
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick16,
    input  logic            rxd,
    input  logic            rx_en,
    input  logic            nine_bit,
    input  logic            par_en,
    input  logic            par_odd,
    input  logic            idle_long,
    input  logic            wake_addr,
    input  logic            rwu_set,
    input  logic            stat_rd,
    output logic [DMAX-2:0] rx_data,
    output logic            rx_bit8,
    output logic            rx_full,
    output logic            err_overrun,
    output logic            err_noise,
    output logic            err_frame,
    output logic            err_parity,
    output logic            idle_det,
    output logic            rx_active,
    output logic            rwu_o
);
    localparam int CW = $clog2((DMAX + 2) * OSR + 1);

    typedef struct packed {
        logic [DMAX-1:0] hold;
        logic            full;
        logic            ovr;
        logic            ferr;
        logic            nerr;
        logic            perr;
        logic            idle;
        logic            rwu;
    } top_regs_t;

    top_regs_t q_q, r_d;

    logic            f_start, f_done, f_noise, f_ferr;
    logic [DMAX-1:0] f_data;
    logic            f_msb, f_accept, f_perr;
    logic            idle_arm, idle_hit;
    logic [CW-1:0]   idle_target;

    uwr_frame #(.OSR(OSR), .DMAX(DMAX)) i_frame (
        .clk(clk), .rst_n(rst_n), .en(rx_en), .tick(tick16), .rxd(rxd),
        .nine(nine_bit), .start_o(f_start), .done_o(f_done), .data_o(f_data),
        .noise_o(f_noise), .ferr_o(f_ferr), .active_o(rx_active)
    );

    assign idle_target = nine_bit ? CW'((DMAX + 2) * OSR) : CW'((DMAX + 1) * OSR);
    assign idle_arm    = idle_long ? f_done : f_start;

    uwr_idle #(.CW(CW)) i_idle (
        .clk(clk), .rst_n(rst_n), .en(rx_en), .tick(tick16), .rxd(rxd),
        .arm(idle_arm), .target(idle_target), .hit_o(idle_hit)
    );

    assign f_msb    = nine_bit ? f_data[DMAX-1] : f_data[DMAX-2];
    assign f_perr   = par_en && ((^f_data) != par_odd);
    assign f_accept = !q_q.rwu || (wake_addr && f_msb);

    always_comb begin
        r_d = q_q;
        if (stat_rd) begin
            r_d.full = 1'b0;
            r_d.ovr  = 1'b0;
            r_d.ferr = 1'b0;
            r_d.nerr = 1'b0;
            r_d.perr = 1'b0;
            r_d.idle = 1'b0;
        end
        if (idle_hit) begin
            r_d.idle = 1'b1;
            if (q_q.rwu && !wake_addr) r_d.rwu = 1'b0;
        end
        if (f_done && f_accept) begin
            r_d.rwu = 1'b0;
            if (q_q.full) begin
                r_d.ovr = 1'b1;
            end else begin
                r_d.hold = f_data;
                r_d.full = 1'b1;
                r_d.ferr = r_d.ferr | f_ferr;
                r_d.nerr = r_d.nerr | f_noise;
                r_d.perr = r_d.perr | f_perr;
            end
        end
        if (rwu_set) r_d.rwu = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= r_d;
    end

    assign rx_data     = q_q.hold[DMAX-2:0];
    assign rx_bit8     = q_q.hold[DMAX-1];
    assign rx_full     = q_q.full;
    assign err_overrun = q_q.ovr;
    assign err_noise   = q_q.nerr;
    assign err_frame   = q_q.ferr;
    assign err_parity  = q_q.perr;
    assign idle_det    = q_q.idle;
    assign rwu_o       = q_q.rwu;

    // R7
    overrun_keeps_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (f_done && f_accept && rx_full) |=> ($stable(rx_data) && $stable(rx_bit8)));

    // R10
    asleep_drops_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rwu_o && !wake_addr && f_done) |=> ($stable(rx_data) && $stable(rx_bit8)));

    // R6
    full_follows_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_full) |-> $past(f_done));

    // R11
    addr_mark_wakes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rwu_o && wake_addr && f_done && f_msb && !rwu_set) |=> !rwu_o);
endmodule

// File: tb/test_uart_wake_rx.sv
module test_uart_wake_rx;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick16 = 1'b0, rxd = 1'b1, rx_en = 1'b1, nine_bit = 1'b0;
    logic par_en = 1'b0, par_odd = 1'b0, idle_long = 1'b1, wake_addr = 1'b0;
    logic rwu_set = 1'b0, stat_rd = 1'b0;
    logic [7:0] rx_data;
    logic rx_bit8, rx_full, err_overrun, err_noise, err_frame, err_parity;
    logic idle_det, rx_active, rwu_o;

    int checks = 0, fails = 0;
    bit finished = 0;
    logic act_mid;

    logic [8:0] m_hold;
    logic m_full, m_ovr, m_ferr, m_nerr, m_perr;

    always #10 clk = ~clk;

    uart_wake_rx i_uart_wake_rx (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd), .rx_en(rx_en),
        .nine_bit(nine_bit), .par_en(par_en), .par_odd(par_odd),
        .idle_long(idle_long), .wake_addr(wake_addr), .rwu_set(rwu_set),
        .stat_rd(stat_rd), .rx_data(rx_data), .rx_bit8(rx_bit8),
        .rx_full(rx_full), .err_overrun(err_overrun), .err_noise(err_noise),
        .err_frame(err_frame), .err_parity(err_parity), .idle_det(idle_det),
        .rx_active(rx_active), .rwu_o(rwu_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic put_tick(input logic v);
        @(negedge clk);
        rxd = v;
        tick16 = 1'b1;
        @(negedge clk);
        tick16 = 1'b0;
    endtask

    task automatic high_ticks(input int n);
        for (int i = 0; i < n; i++) put_tick(1'b1);
    endtask

    task automatic pulse_read();
        @(negedge clk);
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
    endtask

    task automatic pulse_sleep();
        @(negedge clk);
        rwu_set = 1'b1;
        @(negedge clk);
        rwu_set = 1'b0;
    endtask

    // noisy: bit index (0 start, 1..nb data, nb+1 stop) whose slot 9 is flipped, -1 none
    task automatic send_frame(input logic [8:0] dd, input int nb, input logic stopv, input int noisy);
        for (int b = 0; b < nb + 2; b++) begin
            logic bv;
            bv = (b == 0) ? 1'b0 : ((b == nb + 1) ? stopv : dd[b-1]);
            for (int t = 1; t <= 16; t++) begin
                logic v;
                v = (b == noisy && t == 9) ? ~bv : bv;
                put_tick(v);
                if (b == 1 && t == 1) act_mid = rx_active;
            end
        end
    endtask

    function automatic logic [8:0] with_par(input logic [8:0] p, input int nb, input logic odd);
        logic [8:0] low;
        low = p & 9'((1 << (nb - 1)) - 1);
        return low | (9'((^low) ^ odd) << (nb - 1));
    endfunction

    function automatic logic [31:0] pack_obs();
        return {18'd0, rx_bit8, rx_data, rx_full, err_overrun, err_frame, err_noise, err_parity};
    endfunction

    function automatic logic [31:0] pack_exp();
        return {18'd0, m_hold, m_full, m_ovr, m_ferr, m_nerr, m_perr};
    endfunction

    task automatic model_frame(input logic [8:0] dd, input int nb, input logic stopv, input int noisy);
        logic [8:0] mk;
        mk = dd & 9'((1 << nb) - 1);
        if (m_full) m_ovr = 1'b1;
        else begin
            m_hold = mk;
            m_full = 1'b1;
            m_ferr = m_ferr | !stopv;
            m_nerr = m_nerr | (noisy >= 0);
            m_perr = m_perr | (par_en && ((^mk) != par_odd));
        end
    endtask

    task automatic model_clear();
        m_full = 0; m_ovr = 0; m_ferr = 0; m_nerr = 0; m_perr = 0;
    endtask

    initial begin
        #(200000 * 20);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual running expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R6 R12 reset state
        check("R6 reset flags", pack_obs(), 32'd0);
        check("R12 reset active", {idle_det, rx_active, rwu_o}, 0);
        high_ticks(3);

        // R3 8-bit frame, R12 active
        send_frame(9'h0A5, 8, 1'b1, -1);
        high_ticks(4);
        check("R3 8-bit data", {rx_bit8, rx_data, rx_full}, {1'b0, 8'hA5, 1'b1});
        check("R12 active mid frame", act_mid, 1);
        check("R12 inactive after frame", rx_active, 0);
        pulse_read();
        check("R6 read clears full", rx_full, 0);

        // R3 9-bit
        nine_bit = 1'b1;
        send_frame(9'h1C3, 9, 1'b1, -1);
        high_ticks(4);
        check("R3 9-bit data", {rx_bit8, rx_data, rx_full}, {1'b1, 8'hC3, 1'b1});
        pulse_read();
        nine_bit = 1'b0;

        // R4 parity
        par_en = 1'b1; par_odd = 1'b0;
        send_frame(with_par(9'h035, 8, 1'b0), 8, 1'b1, -1);
        high_ticks(4);
        check("R4 good even parity", {err_parity, rx_full}, 2'b01);
        pulse_read();
        send_frame(with_par(9'h035, 8, 1'b0) ^ 9'h080, 8, 1'b1, -1);
        high_ticks(4);
        check("R4 bad even parity", err_parity, 1);
        pulse_read();
        par_odd = 1'b1;
        send_frame(with_par(9'h062, 8, 1'b1), 8, 1'b1, -1);
        high_ticks(4);
        check("R4 good odd parity", err_parity, 0);
        pulse_read();
        par_en = 1'b0; par_odd = 1'b0;

        // R5 framing
        send_frame(9'h03C, 8, 1'b0, -1);
        high_ticks(4);
        check("R5 framing error", {err_frame, rx_full, rx_data}, {2'b11, 8'h3C});
        pulse_read();

        // R2 noise
        send_frame(9'h05A, 8, 1'b1, 4);
        high_ticks(4);
        check("R2 noise flag and data", {err_noise, rx_data}, {1'b1, 8'h5A});
        pulse_read();
        check("R6 read clears noise", err_noise, 0);

        // R1 false start
        for (int t = 1; t <= 16; t++) put_tick(t > 8);
        high_ticks(4);
        check("R1 false start dropped", {rx_full, rx_active}, 2'b00);
        send_frame(9'h0E7, 8, 1'b1, -1);
        high_ticks(4);
        check("R1 frame after false start", {rx_full, rx_data}, {1'b1, 8'hE7});

        // R7 overrun
        send_frame(9'h011, 8, 1'b1, -1);
        high_ticks(4);
        check("R7 overrun keeps data", {err_overrun, rx_full, rx_data}, {2'b11, 8'hE7});
        pulse_read();

        // R13 disabled
        rx_en = 1'b0;
        send_frame(9'h033, 8, 1'b1, -1);
        high_ticks(4);
        check("R13 disabled ignores", {rx_full, rx_active}, 2'b00);
        rx_en = 1'b1;
        high_ticks(2);
        send_frame(9'h066, 8, 1'b1, -1);
        high_ticks(4);
        check("R13 enabled again", {rx_full, rx_data}, {1'b1, 8'h66});
        high_ticks(200);

        // R8 normal idle
        idle_long = 1'b1;
        send_frame(9'h0FF, 8, 1'b1, -1);
        pulse_read();
        high_ticks(150);
        check("R8 idle not yet", idle_det, 0);
        high_ticks(10);
        check("R8 idle after char time", idle_det, 1);
        pulse_read();

        // R9 short idle
        idle_long = 1'b0;
        send_frame(9'h0FF, 8, 1'b1, -1);
        pulse_read();
        high_ticks(10);
        check("R9 short idle not yet", idle_det, 0);
        high_ticks(10);
        check("R9 short idle counted from start", idle_det, 1);
        idle_long = 1'b1;
        high_ticks(200);
        pulse_read();

        // R10 idle wake
        wake_addr = 1'b0;
        pulse_sleep();
        send_frame(9'h011, 8, 1'b1, -1);
        high_ticks(4);
        check("R10 asleep drops frame", {rx_full, rwu_o, rx_data}, {2'b01, 8'hFF});
        high_ticks(160);
        check("R10 idle wakes", rwu_o, 0);
        send_frame(9'h022, 8, 1'b1, -1);
        high_ticks(4);
        check("R10 frame after wake", {rx_full, rx_data}, {1'b1, 8'h22});
        pulse_read();

        // R11 address mark
        wake_addr = 1'b1;
        pulse_sleep();
        send_frame(9'h045, 8, 1'b1, -1);
        high_ticks(170);
        check("R11 non-address and idle ignored", {rx_full, rwu_o}, 2'b01);
        send_frame(9'h09A, 8, 1'b1, -1);
        high_ticks(4);
        check("R11 address frame wakes", {rx_full, rwu_o, rx_data}, {2'b10, 8'h9A});
        wake_addr = 1'b0;
        pulse_read();

        // randomized R2 R3 R4 R5 R6 R7
        m_hold = {rx_bit8, rx_data};
        model_clear();
        for (int it = 0; it < 40; it++) begin
            logic [8:0] dd;
            int nb, noisy;
            logic stopv;
            nine_bit = $urandom_range(0, 1);
            par_en   = $urandom_range(0, 1);
            par_odd  = $urandom_range(0, 1);
            nb = nine_bit ? 9 : 8;
            dd = 9'($urandom);
            if (par_en && $urandom_range(0, 3) != 0) dd = with_par(dd, nb, par_odd);
            noisy = ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, nb + 1)) : -1;
            stopv = ($urandom_range(0, 5) != 0);
            send_frame(dd, nb, stopv, noisy);
            high_ticks(4);
            model_frame(dd, nb, stopv, noisy);
            check("rand R2 R3 R4 R5 R6 R7", pack_obs(), pack_exp());
            if ($urandom_range(0, 2) != 0) begin
                pulse_read();
                model_clear();
            end
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule